// File: doc/BRIEF.md
# Per-CPU Interrupt Claim Interface

This block is the interrupt front end that sits beside one processor core. Level requests arrive already conditioned. Edge or level detection happens upstream, and the shared distributor has already routed its sources to this core. The block keeps one enable bit for each interrupt number and tracks which numbers the core has taken but not yet finished. It drives one interrupt line into the core.

Software works through a small register window of its own. Enables are set and cleared by writing an interrupt number to two separate registers. A read of the claim register returns the number to service and marks it as taken. Writing that number to the completion register releases it. A write to the signal register sends an inter-processor interrupt, carrying a 4-bit ID and a mask of target cores. An inter-processor interrupt arriving from another core is held pending on a fixed number until it is claimed.

Each core has its own 4 KiB window. The windows are laid out one after another by core index, after a 32 KiB shared region. The block decodes only the offset within its own window.

Top module: `cpu_irq_claim_if`

## Requirements
- R1: After reset, all enables, claimed flags, the held inter-processor request and the control bit are clear. `irq_out` and `ipi_tx_valid` are low, and `bus_rdata` is zero.
- R2: Bit 0 of the control register at offset 0x000 switches the interface on, and it reads back in bit 0. While it is 0, `irq_out` stays low and a claim read returns 0xFFFFFFFF.
- R3: Writing a number to offset 0x0A0 sets that number's enable, and writing it to offset 0x0A4 clears it. A written value of NUM_IRQ or more changes no enable.
- R4: `irq_out` is high exactly when the interface is on and at least one number is enabled, pending and not claimed. It follows `src_req` in the same cycle.
- R5: A read of offset 0x06C returns, on `bus_rdata` in the next cycle, the lowest-numbered candidate (enabled, pending and not claimed). That number is marked claimed.
- R6: A claim read with no candidate returns 0xFFFFFFFF and changes no claimed flag.
- R7: A claimed number is never returned again until its number is written to offset 0x0B4. After that write it can be claimed again while it is still pending.
- R8: A write to offset 0x060 with a nonzero target mask in bits 15:8 gives a one-cycle `ipi_tx_valid` pulse in the next cycle. The pulse carries `ipi_tx_id` = bits 3:0 and `ipi_tx_mask` = bits 15:8. A zero mask sends nothing.
- R9: A pulse on `ipi_rx` makes number 15 pending until number 15 is claimed, even after the pulse ends.
- R10: Reads of the write-only offsets and of unmapped offsets return zero and have no side effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Byte offset within this core's window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after `bus_rd` |
| src_req | input | NUM_IRQ | Conditioned level requests, one per number |
| ipi_rx | input | 1 | Incoming inter-processor interrupt pulse |
| irq_out | output | 1 | Interrupt line to the core |
| ipi_tx_valid | output | 1 | Outgoing inter-processor interrupt strobe |
| ipi_tx_id | output | 4 | ID carried by the outgoing request |
| ipi_tx_mask | output | NUM_CPU | Target core mask of the outgoing request |

## Verification
Register writes, claims and completions take effect at the clock edge that ends the bus cycle, so the bench checks their results at the following falling edge. Claim read data and the outgoing inter-processor strobe are each one register deep and are sampled at that same falling edge. `irq_out` is combinational from the request inputs and the block's state, so it is checked a moment after every input change as well as after every bus operation. A bench model that updates its copy of the state once per operation supplies all expected values.

// File: rtl/cic_pkg.sv
package cic_pkg;
   localparam logic [11:0] OFS_CTRL   = 12'h000;
   localparam logic [11:0] OFS_SIG    = 12'h060;
   localparam logic [11:0] OFS_CLAIM  = 12'h06C;
   localparam logic [11:0] OFS_EN_SET = 12'h0A0;
   localparam logic [11:0] OFS_EN_CLR = 12'h0A4;
   localparam logic [11:0] OFS_DONE   = 12'h0B4;
   localparam logic [31:0] NO_IRQ     = 32'hFFFF_FFFF;

   typedef enum logic [2:0] {
      OP_NONE, OP_CTRL_WR, OP_CTRL_RD, OP_SIG_WR,
      OP_CLAIM, OP_SET, OP_CLR, OP_DONE
   } cic_op_e;
endpackage

// File: rtl/cic_enable_bank.sv
module cic_enable_bank #(
   parameter int N    = 64,
   parameter int ID_W = 6
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            set_v,
   input  logic            clr_v,
   input  logic [ID_W-1:0] id,
   output logic [N-1:0]    en
);
   for (genvar i = 0; i < N; i++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            en[i] <= 1'b0;
         else if (set_v && id == ID_W'(i))
            en[i] <= 1'b1;
         else if (clr_v && id == ID_W'(i))
            en[i] <= 1'b0;
      end
   end
endmodule

// File: rtl/cic_claim_arb.sv
module cic_claim_arb #(
   parameter int N    = 64,
   parameter int ID_W = 6
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            gate,
   input  logic [N-1:0]    en,
   input  logic [N-1:0]    pend,
   input  logic            claim_rd,
   input  logic            done_v,
   input  logic [ID_W-1:0] done_id,
   output logic            irq,
   output logic            found,
   output logic [ID_W-1:0] sel_id,
   output logic [N-1:0]    active
);
   logic [N-1:0] cand;

   assign cand = en & pend & ~active & {N{gate}};
   assign irq  = |cand;

   // lowest number wins: scan downward so the last hit is the smallest
   always_comb begin
      found  = 1'b0;
      sel_id = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (cand[i]) begin
            found  = 1'b1;
            sel_id = ID_W'(i);
         end
      end
   end

   for (genvar i = 0; i < N; i++) begin : g_act
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            active[i] <= 1'b0;
         else if (claim_rd && found && sel_id == ID_W'(i))
            active[i] <= 1'b1;
         else if (done_v && done_id == ID_W'(i))
            active[i] <= 1'b0;
      end
   end
endmodule

// File: rtl/cic_ipi_unit.sv
module cic_ipi_unit #(
   parameter int NUM_CPU = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               sig_wr,
   input  logic [3:0]         sig_id,
   input  logic [7:0]         sig_mask,
   input  logic               rx,
   input  logic               taken,
   output logic               held,
   output logic               tx_valid,
   output logic [3:0]         tx_id,
   output logic [NUM_CPU-1:0] tx_mask
);
   logic [NUM_CPU-1:0] mask_w;

   if (NUM_CPU == 8) begin : g_full
      assign mask_w = sig_mask;
   end else begin : g_part
      logic [7-NUM_CPU:0] spare;
      assign mask_w = sig_mask[NUM_CPU-1:0];
      assign spare  = sig_mask[7:NUM_CPU];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         held     <= 1'b0;
         tx_valid <= 1'b0;
         tx_id    <= '0;
         tx_mask  <= '0;
      end else begin
         // a fresh arrival wins over the claim that retires the old one
         held     <= rx | (held & ~taken);
         tx_valid <= sig_wr && (mask_w != '0);
         if (sig_wr) begin
            tx_id   <= sig_id;
            tx_mask <= mask_w;
         end
      end
   end
endmodule

// File: rtl/cpu_irq_claim_if.sv
module cpu_irq_claim_if
   import cic_pkg::*;
#(
   parameter int NUM_IRQ = 64,
   parameter int NUM_CPU = 8,
   parameter int IPI_ID  = 15,
   parameter int ADDR_W  = 12
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               bus_wr,
   input  logic               bus_rd,
   input  logic [ADDR_W-1:0]  bus_addr,
   input  logic [31:0]        bus_wdata,
   output logic [31:0]        bus_rdata,
   input  logic [NUM_IRQ-1:0] src_req,
   input  logic               ipi_rx,
   output logic               irq_out,
   output logic               ipi_tx_valid,
   output logic [3:0]         ipi_tx_id,
   output logic [NUM_CPU-1:0] ipi_tx_mask
);
   localparam int ID_W = $clog2(NUM_IRQ);

   if (NUM_IRQ < 2 || NUM_IRQ > 1024) begin : g_bad_n
      $error("NUM_IRQ out of range");
   end
   if (IPI_ID >= NUM_IRQ || IPI_ID > 15) begin : g_bad_ipi
      $error("IPI_ID must fit the 4-bit field and the ID space");
   end
   if (NUM_CPU < 1 || NUM_CPU > 8) begin : g_bad_cpu
      $error("NUM_CPU must be 1..8");
   end
   if (ADDR_W < 8) begin : g_bad_addr
      $error("ADDR_W too small for the register offsets");
   end

   cic_op_e             op;
   logic                ctrl_q;
   logic                id_ok;
   logic [ID_W-1:0]     wr_id;
   logic [NUM_IRQ-1:0]  en;
   logic [NUM_IRQ-1:0]  pend;
   logic [NUM_IRQ-1:0]  active;
   logic                found;
   logic [ID_W-1:0]     sel_id;
   logic                ipi_held;
   logic                claim_rd;

   assign id_ok    = bus_wdata < 32'(NUM_IRQ);
   assign wr_id    = bus_wdata[ID_W-1:0];
   assign claim_rd = (op == OP_CLAIM);

   always_comb begin
      op = OP_NONE;
      if (bus_wr) begin
         if (bus_addr == ADDR_W'(OFS_CTRL))        op = OP_CTRL_WR;
         else if (bus_addr == ADDR_W'(OFS_SIG))    op = OP_SIG_WR;
         else if (bus_addr == ADDR_W'(OFS_EN_SET)) op = OP_SET;
         else if (bus_addr == ADDR_W'(OFS_EN_CLR)) op = OP_CLR;
         else if (bus_addr == ADDR_W'(OFS_DONE))   op = OP_DONE;
      end else if (bus_rd) begin
         if (bus_addr == ADDR_W'(OFS_CTRL))        op = OP_CTRL_RD;
         else if (bus_addr == ADDR_W'(OFS_CLAIM))  op = OP_CLAIM;
      end
   end

   always_comb begin
      pend         = src_req;
      pend[IPI_ID] = src_req[IPI_ID] | ipi_held;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q    <= 1'b0;
         bus_rdata <= '0;
      end else begin
         if (op == OP_CTRL_WR)
            ctrl_q <= bus_wdata[0];
         if (bus_rd && !bus_wr) begin
            case (op)
               OP_CTRL_RD: bus_rdata <= {31'd0, ctrl_q};
               OP_CLAIM:   bus_rdata <= found ? {{(32-ID_W){1'b0}}, sel_id} : NO_IRQ;
               default:    bus_rdata <= '0;
            endcase
         end
      end
   end

   cic_enable_bank #(.N(NUM_IRQ), .ID_W(ID_W)) u_en (
      .clk   (clk),
      .rst_n (rst_n),
      .set_v (op == OP_SET && id_ok),
      .clr_v (op == OP_CLR && id_ok),
      .id    (wr_id),
      .en    (en)
   );

   cic_claim_arb #(.N(NUM_IRQ), .ID_W(ID_W)) u_arb (
      .clk      (clk),
      .rst_n    (rst_n),
      .gate     (ctrl_q),
      .en       (en),
      .pend     (pend),
      .claim_rd (claim_rd),
      .done_v   (op == OP_DONE && id_ok),
      .done_id  (wr_id),
      .irq      (irq_out),
      .found    (found),
      .sel_id   (sel_id),
      .active   (active)
   );

   cic_ipi_unit #(.NUM_CPU(NUM_CPU)) u_ipi (
      .clk      (clk),
      .rst_n    (rst_n),
      .sig_wr   (op == OP_SIG_WR),
      .sig_id   (bus_wdata[3:0]),
      .sig_mask (bus_wdata[15:8]),
      .rx       (ipi_rx),
      .taken    (claim_rd && found && sel_id == ID_W'(IPI_ID)),
      .held     (ipi_held),
      .tx_valid (ipi_tx_valid),
      .tx_id    (ipi_tx_id),
      .tx_mask  (ipi_tx_mask)
   );
endmodule

// File: rtl/cic_claim_if_chk.sv
module cic_claim_if_chk
   import cic_pkg::*;
#(
   parameter int N       = 64,
   parameter int NUM_CPU = 8,
   parameter int ADDR_W  = 12
) (
   input logic               clk,
   input logic               rst_n,
   input logic               bus_wr,
   input logic               bus_rd,
   input logic [ADDR_W-1:0]  bus_addr,
   input logic               irq_out,
   input logic               ctrl_q,
   input logic [N-1:0]       active,
   input logic               ipi_tx_valid,
   input logic [NUM_CPU-1:0] ipi_tx_mask
);
   logic claim_now;
   logic done_now;
   logic sig_now;

   assign claim_now = bus_rd && !bus_wr && bus_addr == ADDR_W'(OFS_CLAIM);
   assign done_now  = bus_wr && bus_addr == ADDR_W'(OFS_DONE);
   assign sig_now   = bus_wr && bus_addr == ADDR_W'(OFS_SIG);

   a_r2_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !ctrl_q |-> !irq_out);

   a_r8_tx_cause: assert property (@(posedge clk) disable iff (!rst_n)
      ipi_tx_valid |-> $past(sig_now));

   a_r8_tx_mask_set: assert property (@(posedge clk) disable iff (!rst_n)
      ipi_tx_valid |-> (ipi_tx_mask != '0));

   a_r6_empty_read: assert property (@(posedge clk) disable iff (!rst_n)
      (claim_now && !irq_out) |=> $stable(active));

   a_r5_one_per_read: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(active & ~$past(active)));

   a_r7_rise_cause: assert property (@(posedge clk) disable iff (!rst_n)
      (|(active & ~$past(active))) |-> $past(claim_now));

   a_r7_fall_cause: assert property (@(posedge clk) disable iff (!rst_n)
      (|(~active & $past(active))) |-> $past(done_now));
endmodule

bind cpu_irq_claim_if cic_claim_if_chk #(
   .N(NUM_IRQ), .NUM_CPU(NUM_CPU), .ADDR_W(ADDR_W)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .bus_wr       (bus_wr),
   .bus_rd       (bus_rd),
   .bus_addr     (bus_addr),
   .irq_out      (irq_out),
   .ctrl_q       (ctrl_q),
   .active       (active),
   .ipi_tx_valid (ipi_tx_valid),
   .ipi_tx_mask  (ipi_tx_mask)
);

// File: tb/cpu_irq_claim_if_test.sv
module cpu_irq_claim_if_test;
   localparam int NI = 64;
   localparam int NC = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          bus_wr = 1'b0;
   logic          bus_rd = 1'b0;
   logic [11:0]   bus_addr = '0;
   logic [31:0]   bus_wdata = '0;
   logic [31:0]   bus_rdata;
   logic [NI-1:0] src_req = '0;
   logic          ipi_rx = 1'b0;
   logic          irq_out;
   logic          ipi_tx_valid;
   logic [3:0]    ipi_tx_id;
   logic [NC-1:0] ipi_tx_mask;

   int n_chk = 0;
   int n_fail = 0;

   // bench model
   logic [NI-1:0] en_m = '0;
   logic [NI-1:0] act_m = '0;
   logic [NI-1:0] src_m = '0;
   logic          ipi_m = 1'b0;
   logic          ctrl_m = 1'b0;

   always #2 clk = ~clk;

   cpu_irq_claim_if #(.NUM_IRQ(NI), .NUM_CPU(NC), .IPI_ID(15), .ADDR_W(12)) uut (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .src_req(src_req), .ipi_rx(ipi_rx), .irq_out(irq_out),
      .ipi_tx_valid(ipi_tx_valid), .ipi_tx_id(ipi_tx_id), .ipi_tx_mask(ipi_tx_mask)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual %h expected %h", tag, act, exp);
      end
   endtask

   function automatic logic [NI-1:0] cand_m();
      logic [NI-1:0] p;
      p = src_m;
      p[15] = p[15] | ipi_m;
      return en_m & p & ~act_m & {NI{ctrl_m}};
   endfunction

   function automatic int pick_m();
      logic [NI-1:0] c;
      c = cand_m();
      for (int i = 0; i < NI; i++) if (c[i]) return i;
      return -1;
   endfunction

   task automatic chk_irq(input string tag);
      chk(tag, {31'd0, irq_out}, {31'd0, |cand_m()});
   endtask

   task automatic wr(input logic [11:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
      case (a)
         12'h000: ctrl_m = d[0];
         12'h0A0: if (d < NI) en_m[d[5:0]] = 1'b1;
         12'h0A4: if (d < NI) en_m[d[5:0]] = 1'b0;
         12'h0B4: if (d < NI) act_m[d[5:0]] = 1'b0;
         default: ;
      endcase
      if (a == 12'h060) begin
         chk("R8 tx valid", {31'd0, ipi_tx_valid}, {31'd0, d[15:8] != 8'd0});
         if (d[15:8] != 8'd0) begin
            chk("R8 tx id", {28'd0, ipi_tx_id}, {28'd0, d[3:0]});
            chk("R8 tx mask", {24'd0, ipi_tx_mask}, {24'd0, d[15:8]});
         end
      end else begin
         chk("R8 no tx", {31'd0, ipi_tx_valid}, 32'd0);
      end
      chk_irq("R4 after write");
   endtask

   task automatic rd(input logic [11:0] a, input string tag);
      logic [31:0] exp;
      int p;
      exp = 32'd0;
      if (a == 12'h000) exp = {31'd0, ctrl_m};
      else if (a == 12'h06C) begin
         p = pick_m();
         if (p < 0) exp = 32'hFFFF_FFFF;
         else begin
            exp = 32'(p);
            act_m[p] = 1'b1;
            if (p == 15) ipi_m = 1'b0;
         end
      end
      @(negedge clk);
      bus_rd = 1'b1; bus_addr = a;
      @(negedge clk);
      bus_rd = 1'b0;
      chk(tag, bus_rdata, exp);
      chk_irq("R4 after read");
   endtask

   task automatic drive_src(input logic [NI-1:0] v);
      @(negedge clk);
      src_req = v; src_m = v;
      #1;
      chk_irq("R4 src change");
   endtask

   task automatic pulse_ipi();
      @(negedge clk);
      ipi_rx = 1'b1;
      @(negedge clk);
      ipi_rx = 1'b0;
      ipi_m = 1'b1;
      chk_irq("R9 ipi held");
   endtask

   initial begin
      #(4 * 150000);
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      void'($urandom(32'd2718));
      repeat (3) @(negedge clk);
      chk("R1 irq", {31'd0, irq_out}, 32'd0);
      chk("R1 rdata", bus_rdata, 32'd0);
      chk("R1 tx", {31'd0, ipi_tx_valid}, 32'd0);
      rst_n = 1'b1;
      rd(12'h000, "R1 ctrl reads 0");

      // interface off: enabled and pending, still silent
      wr(12'h0A0, 32'd5);
      drive_src(64'h20);
      chk("R2 off irq", {31'd0, irq_out}, 32'd0);
      rd(12'h06C, "R2 off claim none");
      wr(12'h000, 32'd1);
      rd(12'h000, "R2 ctrl readback");
      chk("R4 irq on", {31'd0, irq_out}, 32'd1);

      rd(12'h06C, "R5 claim 5");
      rd(12'h06C, "R7 no reclaim");
      rd(12'h06C, "R6 empty claim");
      wr(12'h0B4, 32'd5);
      rd(12'h06C, "R7 reclaim after done");
      wr(12'h0B4, 32'd5);

      // lowest number first
      wr(12'h0A0, 32'd9);
      wr(12'h0A0, 32'd3);
      drive_src(64'h228);
      rd(12'h06C, "R5 lowest 3");
      rd(12'h06C, "R5 next 5");
      rd(12'h06C, "R5 next 9");
      wr(12'h0B4, 32'd3); wr(12'h0B4, 32'd5); wr(12'h0B4, 32'd9);

      // out-of-range numbers must not alias
      wr(12'h0A4, 32'd3);
      wr(12'h0A0, 32'd67);
      drive_src(64'h8);
      chk("R3 alias ignored", {31'd0, irq_out}, 32'd0);
      wr(12'h0A4, 32'd69);
      wr(12'h0A0, 32'd3);
      chk("R3 set works", {31'd0, irq_out}, 32'd1);
      wr(12'h0A4, 32'd3);
      chk("R3 clear works", {31'd0, irq_out}, 32'd0);

      // incoming inter-processor interrupt
      drive_src('0);
      wr(12'h0A0, 32'd15);
      pulse_ipi();
      chk("R9 held after pulse", {31'd0, irq_out}, 32'd1);
      rd(12'h06C, "R9 claim 15");
      wr(12'h0B4, 32'd15);
      chk("R9 cleared by claim", {31'd0, irq_out}, 32'd0);

      // outgoing
      wr(12'h060, 32'h0000_A50F);
      @(negedge clk);
      chk("R8 single pulse", {31'd0, ipi_tx_valid}, 32'd0);
      wr(12'h060, 32'h0000_000F);

      rd(12'h0A0, "R10 write-only reads 0");
      rd(12'h0FC, "R10 unmapped reads 0");

      // constrained random mix
      for (int it = 0; it < 600; it++) begin
         int op;
         op = int'($urandom % 9);
         if ($urandom % 50 == 0) wr(12'h000, {31'd0, 1'($urandom % 4 != 0)});
         case (op)
            0: wr(12'h0A0, $urandom % 72);
            1: wr(12'h0A4, $urandom % 72);
            2: drive_src({$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom});
            3, 4: rd(12'h06C, "R5 random claim");
            5: begin
               int k;
               k = -1;
               for (int i = 0; i < NI; i++) if (act_m[i] && k < 0 && ($urandom % 3 == 0)) k = i;
               if (k < 0) k = int'($urandom % 70);
               wr(12'h0B4, 32'(k));
            end
            6: pulse_ipi();
            7: wr(12'h060, $urandom & 32'h0000_FF0F);
            default: rd(12'h000, "R2 random ctrl");
         endcase
      end

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule